// File: doc/BRIEF.md
# Pulse-Width Serial Link Master

This block drives and listens to a single-wire link on which each bit is a high pulse and the pulse length carries the value. A short pulse is a zero and a long pulse is a one. A low gap separates consecutive pulses.

The transmit side takes a 64-bit word and a bit count. It emits the selected low-order bits, most significant of them first, and reports busy for as long as the line is in use. The receive side passes the incoming line through a synchroniser and times each high pulse in clock cycles. It shifts the decoded bits into a word. When the line then stays low long enough, it presents the word and its bit count with a valid flag. A pulse that fits neither length window raises an error.

The two paths run on their own. They share one thing: an accepted send clears the receive valid flag. All timing is given in clock cycles through parameters.

Top module: `pwl_master`

## Requirements
- R1: While reset is high and in the first cycle after it, line_out, tx_busy, rx_valid and rx_error are 0, and rx_data and rx_nbits are 0.
- R2: An accepted send with count N > 0 emits only bits N-1 down to 0 of tx_data, in that order (bit N-1 first). Higher bits have no effect on the line.
- R3: Each transmitted bit is a high pulse of ZERO_LEN (18) cycles for 0 or ONE_LEN (88) cycles for 1, followed by GAP_LEN (43) low cycles. line_out is low whenever tx_busy is low.
- R4: A send is accepted when tx_send is high at a clock edge with tx_busy low. tx_busy is high from the next cycle until the last gap ends. A send while tx_busy is high is ignored.
- R5: An accepted send with count 0 drives no pulse, and tx_busy stays low.
- R6: After a two-flop synchroniser, a received high pulse of 14 to 22 cycles decodes as 0 and one of 76 to 99 cycles as 1. The first bit of a word lands at rx_data bit rx_nbits-1, and upper bits are 0.
- R7: Once at least one bit has been received, more than IDLE_LEN (256) consecutive low samples end the word. rx_data and rx_nbits are then updated and rx_valid goes high, and both stay unchanged while rx_valid stays high.
- R8: rx_valid falls at the first pulse of a new word, and in the cycle after a send is accepted.
- R9: A high pulse outside both windows, or a 64th bit in one word, sets rx_error and discards the partial word. rx_error stays high until the next pulse starts, and it is never high together with rx_valid.
- R10: Transmitting while a word is being received does not alter the received word or its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for logic and line timing |
| rst | input | 1 | Synchronous active-high reset |
| tx_nbits | input | 6 | Number of bits to transmit |
| tx_data | input | 64 | Word whose low bits are transmitted |
| tx_send | input | 1 | One-cycle transmit request |
| tx_busy | output | 1 | Transmission in progress |
| rx_nbits | output | 6 | Bit count of the last complete word |
| rx_data | output | 64 | Last complete word, right aligned |
| rx_valid | output | 1 | rx_data/rx_nbits hold a complete word |
| rx_error | output | 1 | Last received pulse had an illegal length |
| line_in | input | 1 | Serial line from the far end |
| line_out | output | 1 | Serial line to the far end |

## Verification
Some rules can be judged from one cycle or from one cycle and the next, and the assertions check these on every clock. They cover: busy rising after a send with a non-zero count, busy staying low after a send with a zero count, a silent line while idle, valid clearing after a send, error and valid never being high together, and a held word staying stable. Other behaviour depends on how long a pulse is and on the order of the bits, and only the bench's scenarios can show it. This covers the exact pulse and gap lengths, the bit order on transmit, the decode limits at 14, 22, 76 and 99 cycles and just outside them, the idle timeout, overflow at the 64th bit, and a loopback and an overlapped transmit/receive.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    localparam int DATA_W = 64;
    localparam int NB_W   = 6;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PULSE,
        TX_GAP
    } tx_state_e;

    typedef enum logic [1:0] {
        PW_ZERO,
        PW_ONE,
        PW_BAD
    } pw_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NB_W-1:0]   nbits;
    } word_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Map a measured high time onto a symbol
    function automatic pw_class_e classify(input int len, input int zmin, input int zmax,
                                           input int omin, input int omax);
        if (len >= zmin && len <= zmax) return PW_ZERO;
        if (len >= omin && len <= omax) return PW_ONE;
        return PW_BAD;
    endfunction

endpackage

// File: rtl/pwl_sync.sv
module pwl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/pwl_tx.sv
module pwl_tx import pwl_pkg::*; #(
    parameter int ZERO_LEN = 18,
    parameter int ONE_LEN  = 88,
    parameter int GAP_LEN  = 43,
    parameter int CNT_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [NB_W-1:0]   nbits_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              accept,
    output logic              line_out
);
    localparam logic [CNT_W-1:0] ZERO_M1 = CNT_W'(ZERO_LEN - 1);
    localparam logic [CNT_W-1:0] ONE_M1  = CNT_W'(ONE_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_LEN - 1);

    tx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [NB_W-1:0]   idx;
    logic [DATA_W-1:0] word;

    function automatic logic [CNT_W-1:0] high_m1(input logic b);
        return b ? ONE_M1 : ZERO_M1;
    endfunction

    assign accept   = send && (st == TX_IDLE);
    assign busy     = (st != TX_IDLE);
    assign line_out = (st == TX_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            word <= '0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (accept && nbits_in != '0) begin
                        word <= data_in;
                        idx  <= nbits_in - 1'b1;
                        cnt  <= high_m1(data_in[nbits_in - 1'b1]);
                        st   <= TX_PULSE;
                    end
                end
                TX_PULSE: begin
                    if (cnt == '0) begin
                        cnt <= GAP_M1;
                        st  <= TX_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                TX_GAP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (idx == '0) begin
                        st <= TX_IDLE;
                    end else begin
                        idx <= idx - 1'b1;
                        cnt <= high_m1(word[idx - 1'b1]);
                        st  <= TX_PULSE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwl_rx.sv
module pwl_rx import pwl_pkg::*; #(
    parameter int ZERO_MIN = 14,
    parameter int ZERO_MAX = 22,
    parameter int ONE_MIN  = 76,
    parameter int ONE_MAX  = 99,
    parameter int IDLE_LEN = 256,
    parameter int CNT_W    = 9
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line,
    input  logic  clear_valid,
    output word_t word_out,
    output logic  valid,
    output logic  err
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;
    localparam logic [CNT_W-1:0] IDLE_AT = CNT_W'(IDLE_LEN);

    logic             level_q;
    logic             active;
    logic [CNT_W-1:0] run;
    word_t            acc;
    pw_class_e        cls;

    assign cls = classify(int'(run), ZERO_MIN, ZERO_MAX, ONE_MIN, ONE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= 1'b0;
            active   <= 1'b0;
            run      <= '0;
            acc      <= '0;
            word_out <= '0;
            valid    <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (line != level_q) begin
                level_q <= line;
                run     <= CNT_W'(1);
                if (line) begin
                    err <= 1'b0;
                    if (!active) begin
                        active <= 1'b1;
                        acc    <= '0;
                        valid  <= 1'b0;
                    end
                end else if (cls == PW_BAD || (&acc.nbits)) begin
                    err    <= 1'b1;
                    active <= 1'b0;
                end else begin
                    acc.data  <= {acc.data[DATA_W-2:0], (cls == PW_ONE)};
                    acc.nbits <= acc.nbits + 1'b1;
                end
            end else begin
                if (run != RUN_MAX) run <= run + 1'b1;
                if (!line && active && run == IDLE_AT) begin
                    word_out <= acc;
                    valid    <= 1'b1;
                    active   <= 1'b0;
                end
            end
            if (clear_valid) valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pwl_master.sv
module pwl_master import pwl_pkg::*; #(
    parameter int ZERO_LEN    = 18,
    parameter int ONE_LEN     = 88,
    parameter int GAP_LEN     = 43,
    parameter int ZERO_MIN    = 14,
    parameter int ZERO_MAX    = 22,
    parameter int ONE_MIN     = 76,
    parameter int ONE_MAX     = 99,
    parameter int IDLE_LEN    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB_W-1:0]   tx_nbits,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_send,
    output logic              tx_busy,
    output logic [NB_W-1:0]   rx_nbits,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_error,
    input  logic              line_in,
    output logic              line_out
);
    localparam int CNT_W = $clog2(max_of(max_of(ONE_MAX, ONE_LEN),
                                         max_of(GAP_LEN, IDLE_LEN)) + 2);

    logic  tx_accept;
    logic  line_sync;
    word_t rx_word;

    pwl_tx #(
        .ZERO_LEN (ZERO_LEN),
        .ONE_LEN  (ONE_LEN),
        .GAP_LEN  (GAP_LEN),
        .CNT_W    (CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .send     (tx_send),
        .nbits_in (tx_nbits),
        .data_in  (tx_data),
        .busy     (tx_busy),
        .accept   (tx_accept),
        .line_out (line_out)
    );

    pwl_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_sync)
    );

    pwl_rx #(
        .ZERO_MIN (ZERO_MIN),
        .ZERO_MAX (ZERO_MAX),
        .ONE_MIN  (ONE_MIN),
        .ONE_MAX  (ONE_MAX),
        .IDLE_LEN (IDLE_LEN),
        .CNT_W    (CNT_W)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .line        (line_sync),
        .clear_valid (tx_accept),
        .word_out    (rx_word),
        .valid       (rx_valid),
        .err         (rx_error)
    );

    assign rx_data  = rx_word.data;
    assign rx_nbits = rx_word.nbits;
endmodule

// File: rtl/pwl_master_chk.sv
module pwl_master_chk import pwl_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic [NB_W-1:0]   tx_nbits,
    input logic              tx_send,
    input logic              tx_busy,
    input logic [NB_W-1:0]   rx_nbits,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_error,
    input logic              line_out
);
    // R4
    tx_busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_send && !tx_busy && tx_nbits != '0) |=> tx_busy);

    // R5
    tx_empty_send_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_send && !tx_busy && tx_nbits == '0) |=> !tx_busy);

    // R3
    tx_quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> !line_out);

    // R8
    rx_send_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_send && !tx_busy) |=> !rx_valid);

    // R9
    rx_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> !rx_valid);

    // R7
    rx_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rx_valid)) |-> ($stable(rx_data) && $stable(rx_nbits)));
endmodule

bind pwl_master pwl_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_nbits (tx_nbits),
    .tx_send  (tx_send),
    .tx_busy  (tx_busy),
    .rx_nbits (rx_nbits),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_error (rx_error),
    .line_out (line_out)
);

// File: tb/tb_pwl_master.sv
`timescale 1ns/1ps
module tb_pwl_master;
    localparam int ZL = 18, OL = 88, GL = 43;
    localparam int ZMIN = 14, ZMAX = 22, OMIN = 76, OMAX = 99, IDLE = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  tx_nbits = '0;
    logic [63:0] tx_data = '0;
    logic        tx_send = 1'b0;
    logic        tx_busy;
    logic [5:0]  rx_nbits;
    logic [63:0] rx_data;
    logic        rx_valid, rx_error;
    logic        line_in, line_out;
    logic        drv = 1'b0;
    logic        loop_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    assign line_in = loop_en ? line_out : drv;

    always #10 clk = ~clk;

    pwl_master dut (
        .clk(clk), .rst(rst), .tx_nbits(tx_nbits), .tx_data(tx_data),
        .tx_send(tx_send), .tx_busy(tx_busy), .rx_nbits(rx_nbits),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_error(rx_error),
        .line_in(line_in), .line_out(line_out)
    );

    // ---------------- behavioural reference ----------------
    bit          txq[$];
    bit          rxq[$];
    bit          d1, d2, lvl, act, started;
    int          run;
    logic [63:0] e_data;
    int          e_nb;
    bit          e_valid, e_err;

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            d1 = 0; d2 = 0; lvl = 0; act = 0; run = 0;
            e_data = '0; e_nb = 0; e_valid = 0; e_err = 0;
            started = 1;
        end else begin
            bit busy_pre, acc, s;
            busy_pre = (txq.size() != 0);
            acc = tx_send && !busy_pre;
            if (txq.size() != 0) void'(txq.pop_front());
            if (acc && tx_nbits != 0) begin
                for (int i = int'(tx_nbits) - 1; i >= 0; i--) begin
                    repeat (tx_data[i] ? OL : ZL) txq.push_back(1'b1);
                    repeat (GL) txq.push_back(1'b0);
                end
            end
            s = d2; d2 = d1; d1 = line_in;
            if (s != lvl) begin
                lvl = s;
                if (s) begin
                    e_err = 0;
                    if (!act) begin act = 1; rxq.delete(); e_valid = 0; end
                end else begin
                    if (run >= ZMIN && run <= ZMAX && rxq.size() < 63) rxq.push_back(1'b0);
                    else if (run >= OMIN && run <= OMAX && rxq.size() < 63) rxq.push_back(1'b1);
                    else begin e_err = 1; act = 0; end
                end
                run = 1;
            end else begin
                run++;
                if (!s && act && run == IDLE + 1) begin
                    e_data = '0;
                    foreach (rxq[k]) e_data = {e_data[62:0], rxq[k]};
                    e_nb = rxq.size();
                    e_valid = 1;
                    act = 0;
                end
            end
            if (acc) e_valid = 0;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act_v, input logic [63:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R2 R3", "line_out", 64'(line_out), 64'(txq.size() != 0 ? txq[0] : 1'b0));
            chk("R4", "tx_busy", 64'(tx_busy), 64'(txq.size() != 0));
            chk("R6", "rx_data", rx_data, e_data);
            chk("R6", "rx_nbits", 64'(rx_nbits), 64'(e_nb));
            chk("R7 R8", "rx_valid", 64'(rx_valid), 64'(e_valid));
            chk("R9", "rx_error", 64'(rx_error), 64'(e_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) drv = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk) drv = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic do_send(input logic [5:0] n, input logic [63:0] d);
        @(negedge clk);
        tx_send = 1'b1; tx_nbits = n; tx_data = d;
        @(negedge clk);
        tx_send = 1'b0;
    endtask

    task automatic wait_tx;
        @(negedge clk);
        while (tx_busy) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs right after reset
        chk("R1", "reset outputs", {rx_data[59:0], line_out, tx_busy, rx_valid, rx_error}, 64'h0);
        chk("R1", "reset count", 64'(rx_nbits), 64'h0);

        // R2 R3: six bits 101101, upper bits set but unused
        do_send(6'd6, 64'hFFFF_FFFF_FFFF_FFED);
        idle(5);
        // R4: request while busy is ignored
        do_send(6'd3, 64'h0);
        wait_tx();
        idle(5);

        // R5: zero-length send
        do_send(6'd0, 64'hFFFF);
        idle(3);
        chk("R5", "busy after empty send", 64'(tx_busy), 64'h0);
        chk("R5", "line after empty send", 64'(line_out), 64'h0);

        // R6 R7: window edges 14,22 -> 0 and 76,99 -> 1
        pulse(14, 43); pulse(22, 43); pulse(76, 43); pulse(99, 43);
        pulse(18, 43); pulse(88, 43);
        idle(300);
        chk("R6", "decoded word", rx_data, 64'h0D);
        chk("R7", "word valid", 64'(rx_valid), 64'h1);

        // R8: new word clears valid at its first pulse
        pulse(88, 300);
        idle(10);
        chk("R6", "single bit word", {rx_data[57:0], rx_nbits}, {58'h1, 6'd1});

        // R8: accepted send clears valid
        do_send(6'd2, 64'h2);
        chk("R8", "valid after send", 64'(rx_valid), 64'h0);
        wait_tx();

        // R9: lengths just outside the windows
        pulse(13, 40);
        chk("R9", "short pulse error", 64'(rx_error), 64'h1);
        pulse(23, 40); pulse(75, 40); pulse(100, 40);
        pulse(88, 43); pulse(18, 43); pulse(50, 300);
        chk("R9", "discarded word", 64'(rx_valid), 64'h0);
        pulse(18, 43); pulse(88, 300);
        chk("R9", "recovery word", {rx_data[57:0], rx_nbits}, {58'h1, 6'd2});

        // R9: 64th bit overflows
        for (int i = 0; i < 64; i++) pulse(18, 30);
        idle(300);
        chk("R9", "overflow error", 64'(rx_error), 64'h1);

        // R6 R10: loopback of own transmission
        loop_en = 1'b1;
        do_send(6'd8, 64'hA5);
        wait_tx();
        idle(300);
        loop_en = 1'b0;
        chk("R10", "loopback word", {rx_data[57:0], rx_nbits}, {58'hA5, 6'd8});

        // R10: transmit overlapping a reception
        fork
            do_send(6'd4, 64'h9);
            begin pulse(88, 43); pulse(18, 43); pulse(88, 300); end
        join
        wait_tx();
        idle(20);
        chk("R10", "overlapped word", {rx_data[57:0], rx_nbits}, {58'h5, 6'd3});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule